// File: doc/BRIEF.md
# SCSI Protocol Controller Register File

This block is the register file that a host processor sees on a simple SCSI protocol controller. The host reaches nine byte-wide locations through a byte read/write port. Indices 0 to 7 are the controller registers. Index 8 is a pseudo-DMA data port, which moves one byte to or from the bus on every access. The block sits between that host port and a bus-phase sequencer. The sequencer reports the live bus state (busy, phase, REQ, SEL, RST) and the byte the target presents. It receives the output byte together with one-cycle put and take strobes. The block drives the initiator control lines (data-bus enable, ATN, SEL, BSY, ACK, RST) from the initiator command register. It also raises an interrupt when a data transfer finds the bus in a phase other than the one the host expects.

Two state machines hold the sequencing. The DMA machine has the states DMA_IDLE, DMA_SEND, DMA_TRECV and DMA_IRECV. A start write to index 5, 6 or 7 made while DMA mode is set moves it from any state into DMA_SEND, DMA_TRECV or DMA_IRECV respectively. A write that clears DMA mode, or a bus reset command, moves it to DMA_IDLE. The interrupt machine has the states IRQ_IDLE, IRQ_HOLD and IRQ_ACTIVE. A phase mismatch moves it from IRQ_IDLE to IRQ_HOLD, or straight to IRQ_ACTIVE when no hold is configured. It moves from IRQ_HOLD to IRQ_ACTIVE after the configured hold. A read of index 7 or a bus reset command moves it from any state to IRQ_IDLE.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After reset every register reads 0, all drive outputs and strobes are low and irq_o is low.
- R2: Writing index 1 stores bits 0 to 4, which drive data enable (bit 0), ATN (bit 1), SEL (bit 2), BSY (bit 3) and ACK (bit 4). Bits 5 and 6 are read-only and keep their value (0 after reset). Bit 7 reads back as 0.
- R3: drv_data_o is held low whenever bus_busy_i is high and phase bit 0 (I/O, 1 = target to initiator) is set.
- R4: drv_ack_o follows command bit 4 only while mode bit 1 (DMA mode) is clear. While DMA mode is set it is low.
- R5: Writing index 1 with bit 7 set clears all registers and both state machines, and pulses drv_rst_o for one cycle.
- R6: Writes to index 5, 6 and 7 start send, target-receive and initiator-receive DMA only while DMA mode is set, and their data is discarded. With no DMA controller, status (index 5) bit 6 reports a DMA request while DMA is active. With a DMA controller present, status bit 6 stays 0.
- R7: A mode write with bit 1 clear ends DMA and clears status bits 7 and 6.
- R8: A read of index 0 returns bus_din_i without a take strobe. A read of index 6 returns it with a take strobe only while DMA is active. Any access to index 8 gives a take strobe (read) or a put strobe (write). A write to index 0 gives a put strobe only when drv_data_o is high and either the bus is free or DMA mode is set with DMA active. Strobes and bus_dout_o appear in the cycle after the access.
- R9: A read of index 6 or 8, or any put, sets the interrupt when mode bit 6 is clear and the bus is free or bus_phase_i differs from index 3 bits 2:0. Status bit 4 reports the interrupt. When mode bit 6 is set, no interrupt is raised.
- R10: With a DMA controller present, a raised interrupt also sets status bit 7 and index 3 bit 7. Without one, both stay clear.
- R11: A read of index 7 clears the interrupt (status bit 4 and irq_o) and returns 0.
- R12: irq_o goes high IRQ_HOLD cycles after the edge that sets status bit 4.
- R13: Accesses to index 9 and above change no register, and reads of them return 0.
- R14: Index 4 reads the live bus as bit 7 RST, bit 6 BSY, bit 5 REQ, bits 4:2 phase (MSG, C/D, I/O), bit 1 SEL, bit 0 zero. Status bit 3 is set while the bus is busy and its phase equals index 3 bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | AW | Register index |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Read byte, valid the cycle after the read |
| bus_busy_i | input | 1 | A target holds the bus (phase valid) |
| bus_phase_i | input | 3 | Bus phase {MSG, C/D, I/O} |
| bus_req_i | input | 1 | Live REQ line |
| bus_sel_i | input | 1 | Live SEL line |
| bus_rst_i | input | 1 | Live RST line |
| bus_din_i | input | DW | Byte presented by the sequencer |
| bus_dout_o | output | DW | Output data byte |
| bus_put_o | output | 1 | One-cycle strobe: put bus_dout_o on the bus |
| bus_take_o | output | 1 | One-cycle strobe: advance to the next input byte |
| drv_data_o | output | 1 | Data bus drive enable |
| drv_atn_o | output | 1 | ATN drive |
| drv_sel_o | output | 1 | SEL drive |
| drv_bsy_o | output | 1 | BSY drive |
| drv_ack_o | output | 1 | ACK drive |
| drv_rst_o | output | 1 | Bus reset pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a phase-mismatch interrupt that reports correctly under both build options. It must set the end-of-DMA and last-byte flags only when a DMA controller is present, and it must reach irq_o only after the hold. A bus reset command arriving mid-transfer must also clear everything. The bench places two instances side by side, one without a DMA controller and with a two-cycle hold, the other with a DMA controller and no hold. It drives the sequencer inputs directly to hold a busy bus in a chosen phase. It then changes the phase and reads the pseudo-DMA port, and it samples irq_o of both instances on each of the following cycles.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

    typedef enum logic [1:0] {
        DMA_IDLE,
        DMA_SEND,
        DMA_TRECV,
        DMA_IRECV
    } dma_state_t;

    typedef enum logic [1:0] {
        IRQ_IDLE,
        IRQ_HOLD,
        IRQ_ACTIVE
    } irq_state_t;

    // register indices whose position the host software decodes
    localparam int unsigned IDX_DATA = 0;
    localparam int unsigned IDX_ICR  = 1;
    localparam int unsigned IDX_MODE = 2;
    localparam int unsigned IDX_TCR  = 3;
    localparam int unsigned IDX_BUS  = 4;
    localparam int unsigned IDX_STAT = 5;
    localparam int unsigned IDX_IN   = 6;
    localparam int unsigned IDX_ACKI = 7;
    localparam int unsigned IDX_PORT = 8;

    // bit positions
    localparam int unsigned ICR_RST    = 7;
    localparam int unsigned MODE_DMA   = 1;
    localparam int unsigned MODE_NOCHK = 6;
    localparam int unsigned FLAG_BIT   = 7;

endpackage

// File: rtl/sreg_bus_drive.sv
module sreg_bus_drive (
    input  logic [4:0] cmd_lo,
    input  logic       dma_mode,
    input  logic       bus_busy,
    input  logic       tgt_to_init,
    output logic       drv_data,
    output logic       drv_atn,
    output logic       drv_sel,
    output logic       drv_bsy,
    output logic       drv_ack
);
    always_comb begin
        // data enable is withdrawn whenever the target owns the direction
        drv_data = cmd_lo[0] & ~(bus_busy & tgt_to_init);
        drv_atn  = cmd_lo[1];
        drv_sel  = cmd_lo[2];
        drv_bsy  = cmd_lo[3];
        // in DMA mode the handshake belongs to the transfer logic
        drv_ack  = cmd_lo[4] & ~dma_mode;
    end
endmodule

// File: rtl/sreg_dma_fsm.sv
module sreg_dma_fsm
    import scsi_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic go_send,
    input  logic go_trecv,
    input  logic go_irecv,
    output logic active
);
    dma_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DMA_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d = DMA_IDLE;
        end else begin
            unique case (st_q)
                DMA_IDLE, DMA_SEND, DMA_TRECV, DMA_IRECV: begin
                    if (go_send)       st_d = DMA_SEND;
                    else if (go_trecv) st_d = DMA_TRECV;
                    else if (go_irecv) st_d = DMA_IRECV;
                end
                default: st_d = DMA_IDLE;
            endcase
        end
    end

    always_comb begin
        active = (st_q != DMA_IDLE);
    end

    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !active);
    p_start_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((go_send || go_trecv || go_irecv) && !stop) |=> active);
endmodule

// File: rtl/sreg_irq_fsm.sv
module sreg_irq_fsm
    import scsi_regs_pkg::*;
#(
    parameter int unsigned HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic raise,
    input  logic clear,
    output logic pend,
    output logic irq
);
    localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'((HOLD > 0) ? HOLD - 1 : 0);

    irq_state_t      st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= IRQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (soft_rst || clear) begin
            st_d  = IRQ_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                IRQ_IDLE: begin
                    if (raise) begin
                        cnt_d = '0;
                        st_d  = (HOLD == 0) ? IRQ_ACTIVE : IRQ_HOLD;
                    end
                end
                IRQ_HOLD: begin
                    if (cnt_q == LAST) st_d = IRQ_ACTIVE;
                    else               cnt_d = cnt_q + 1'b1;
                end
                IRQ_ACTIVE: begin
                    st_d = IRQ_ACTIVE;
                end
                default: st_d = IRQ_IDLE;
            endcase
        end
    end

    always_comb begin
        pend = (st_q != IRQ_IDLE);
        irq  = (st_q == IRQ_ACTIVE);
    end

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pend);
    p_late_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD != 0 && $rose(pend)) |-> !irq);
    p_hold_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == IRQ_HOLD) |-> (cnt_q <= LAST));
endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
    import scsi_regs_pkg::*;
#(
    parameter int unsigned DW           = 8,
    parameter int unsigned AW           = 4,
    parameter int unsigned NREG         = 9,
    parameter int unsigned PW           = 3,
    parameter int unsigned HAS_DMA_CTRL = 0,
    parameter int unsigned IRQ_HOLD     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          bus_busy_i,
    input  logic [PW-1:0] bus_phase_i,
    input  logic          bus_req_i,
    input  logic          bus_sel_i,
    input  logic          bus_rst_i,
    input  logic [DW-1:0] bus_din_i,
    output logic [DW-1:0] bus_dout_o,
    output logic          bus_put_o,
    output logic          bus_take_o,
    output logic          drv_data_o,
    output logic          drv_atn_o,
    output logic          drv_sel_o,
    output logic          drv_bsy_o,
    output logic          drv_ack_o,
    output logic          drv_rst_o,
    output logic          irq_o
);
    localparam int unsigned PH_LSB = 2;

    logic [DW-1:0]   odr_q, icr_q, mode_q, tcr_q, rdata_q;
    logic            eod_q, put_q, take_q, rst_q;
    logic [NREG-1:0] hit, wr_hit, rd_hit;
    logic            wr_en, rd_en;
    logic            rst_cmd, mode_stop, dma_go, dma_active;
    logic            put_now, take_now, check, mismatch, raise, phase_ok;
    logic            irq_pend, dreq, flag_set;
    logic [DW-1:0]   stat, snap, rd_mux;

    assign wr_en = host_wr;
    assign rd_en = host_rd & ~host_wr;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g]    = (host_addr == AW'(g));
        assign wr_hit[g] = hit[g] & wr_en;
        assign rd_hit[g] = hit[g] & rd_en;
    end

    assign rst_cmd   = wr_hit[IDX_ICR] & host_wdata[ICR_RST];
    assign mode_stop = wr_hit[IDX_MODE] & ~host_wdata[MODE_DMA];
    assign dma_go    = mode_q[MODE_DMA] & ~rst_cmd;

    sreg_bus_drive u_drive (
        .cmd_lo      (icr_q[4:0]),
        .dma_mode    (mode_q[MODE_DMA]),
        .bus_busy    (bus_busy_i),
        .tgt_to_init (bus_phase_i[0]),
        .drv_data    (drv_data_o),
        .drv_atn     (drv_atn_o),
        .drv_sel     (drv_sel_o),
        .drv_bsy     (drv_bsy_o),
        .drv_ack     (drv_ack_o)
    );

    sreg_dma_fsm u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (rst_cmd | mode_stop),
        .go_send  (dma_go & wr_hit[IDX_STAT]),
        .go_trecv (dma_go & wr_hit[IDX_IN]),
        .go_irecv (dma_go & wr_hit[IDX_ACKI]),
        .active   (dma_active)
    );

    assign put_now  = wr_hit[IDX_PORT]
                    | (wr_hit[IDX_DATA] & drv_data_o
                       & ((mode_q[MODE_DMA] & dma_active) | ~bus_busy_i));
    assign take_now = rd_hit[IDX_PORT] | (rd_hit[IDX_IN] & dma_active);
    assign check    = put_now | rd_hit[IDX_IN] | rd_hit[IDX_PORT];
    assign mismatch = ~bus_busy_i | (bus_phase_i != tcr_q[PW-1:0]);
    assign phase_ok = bus_busy_i & (bus_phase_i == tcr_q[PW-1:0]);
    assign raise    = check & ~mode_q[MODE_NOCHK] & mismatch;

    sreg_irq_fsm #(.HOLD(IRQ_HOLD)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (rst_cmd),
        .raise    (raise),
        .clear    (rd_hit[IDX_ACKI]),
        .pend     (irq_pend),
        .irq      (irq_o)
    );

    if (HAS_DMA_CTRL != 0) begin : g_dc
        assign dreq     = 1'b0;
        assign flag_set = raise;
        p_flags_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (raise && !mode_stop) |=> (eod_q && tcr_q[FLAG_BIT]));
    end else begin : g_nodc
        assign dreq     = dma_active;
        assign flag_set = 1'b0;
    end

    always_comb begin
        snap           = '0;
        snap[7]        = bus_rst_i;
        snap[6]        = bus_busy_i;
        snap[5]        = bus_req_i;
        snap[PH_LSB+PW-1:PH_LSB] = bus_phase_i;
        snap[1]        = bus_sel_i;
        stat           = '0;
        stat[7]        = eod_q;
        stat[6]        = dreq;
        stat[4]        = irq_pend;
        stat[3]        = phase_ok;
    end

    always_comb begin
        rd_mux = '0;
        if (hit[IDX_DATA] || hit[IDX_IN] || hit[IDX_PORT]) rd_mux = bus_din_i;
        else if (hit[IDX_ICR])  rd_mux = icr_q;
        else if (hit[IDX_MODE]) rd_mux = mode_q;
        else if (hit[IDX_TCR])  rd_mux = tcr_q;
        else if (hit[IDX_BUS])  rd_mux = snap;
        else if (hit[IDX_STAT]) rd_mux = stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odr_q   <= '0;
            icr_q   <= '0;
            mode_q  <= '0;
            tcr_q   <= '0;
            rdata_q <= '0;
            eod_q   <= 1'b0;
            put_q   <= 1'b0;
            take_q  <= 1'b0;
            rst_q   <= 1'b0;
        end else if (rst_cmd) begin
            odr_q   <= '0;
            icr_q   <= '0;
            mode_q  <= '0;
            tcr_q   <= '0;
            rdata_q <= '0;
            eod_q   <= 1'b0;
            put_q   <= 1'b0;
            take_q  <= 1'b0;
            rst_q   <= 1'b1;
        end else begin
            rst_q  <= 1'b0;
            put_q  <= put_now;
            take_q <= take_now;
            if (rd_en) rdata_q <= rd_mux;
            if (wr_hit[IDX_DATA] || wr_hit[IDX_PORT]) odr_q <= host_wdata;
            if (wr_hit[IDX_ICR]) icr_q[4:0] <= host_wdata[4:0];
            if (wr_hit[IDX_MODE]) begin
                mode_q <= host_wdata;
                if (!host_wdata[MODE_DMA]) eod_q <= 1'b0;
            end
            if (wr_hit[IDX_TCR]) tcr_q <= host_wdata;
            if (flag_set) begin
                eod_q           <= 1'b1;
                tcr_q[FLAG_BIT] <= 1'b1;
            end
        end
    end

    assign host_rdata = rdata_q;
    assign bus_dout_o = odr_q;
    assign bus_put_o  = put_q;
    assign bus_take_o = take_q;
    assign drv_rst_o  = rst_q;

    p_dbe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy_i && bus_phase_i[0]) |-> !drv_data_o);
    p_ack_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[MODE_DMA] |-> !drv_ack_o);
    p_take_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_take_o |-> $past(rd_en));
    p_put_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_put_o |-> $past(host_wr));
    p_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raise && !irq_pend) |=> irq_pend);
    p_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(|hit)) |=> ($stable(icr_q) && $stable(mode_q)
                                && $stable(tcr_q) && $stable(odr_q)));
    p_rst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drv_rst_o |-> (icr_q == '0 && mode_q == '0 && tcr_q == '0 && !irq_pend));
endmodule

// File: tb/scsi_ctl_regs_tb.sv
`timescale 1ns/1ps
module scsi_ctl_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic       busy = 1'b0, req = 1'b0, sel = 1'b0, brst = 1'b0;
    logic [2:0] phase = '0;
    logic [7:0] din = '0;

    logic [7:0] rdata, dout, dc_rdata, dc_dout;
    logic put, take, d_data, d_atn, d_sel, d_bsy, d_ack, d_rst, irq;
    logic dc_put, dc_take, dc_data, dc_atn, dc_sel, dc_bsy, dc_ack, dc_rst, dc_irq;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;
    logic put_seen, take_seen, rst_seen;
    logic [7:0] d, dd;

    always #2 clk = ~clk;

    scsi_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wr(wr), .host_rd(rd),
        .host_wdata(wdata), .host_rdata(rdata), .bus_busy_i(busy),
        .bus_phase_i(phase), .bus_req_i(req), .bus_sel_i(sel), .bus_rst_i(brst),
        .bus_din_i(din), .bus_dout_o(dout), .bus_put_o(put), .bus_take_o(take),
        .drv_data_o(d_data), .drv_atn_o(d_atn), .drv_sel_o(d_sel),
        .drv_bsy_o(d_bsy), .drv_ack_o(d_ack), .drv_rst_o(d_rst), .irq_o(irq)
    );

    scsi_ctl_regs #(.HAS_DMA_CTRL(1), .IRQ_HOLD(0)) u_dut_dc (
        .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wr(wr), .host_rd(rd),
        .host_wdata(wdata), .host_rdata(dc_rdata), .bus_busy_i(busy),
        .bus_phase_i(phase), .bus_req_i(req), .bus_sel_i(sel), .bus_rst_i(brst),
        .bus_din_i(din), .bus_dout_o(dc_dout), .bus_put_o(dc_put), .bus_take_o(dc_take),
        .drv_data_o(dc_data), .drv_atn_o(dc_atn), .drv_sel_o(dc_sel),
        .drv_bsy_o(dc_bsy), .drv_ack_o(dc_ack), .drv_rst_o(dc_rst), .irq_o(dc_irq)
    );

    wire [4:0] drv_vec = {d_ack, d_bsy, d_sel, d_atn, d_data};

    function automatic logic [4:0] exp_drv(input logic [7:0] icr, input logic [7:0] mode,
                                           input logic bsy, input logic [2:0] ph);
        return {icr[4] & ~mode[1], icr[3], icr[2], icr[1], icr[0] & ~(bsy & ph[0])};
    endfunction

    task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [7:0] v);
        @(negedge clk);
        addr = 4'(a); wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        put_seen = put; take_seen = take; rst_seen = d_rst;
    endtask

    task automatic rd_reg(input int a);
        @(negedge clk);
        addr = 4'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata; dd = dc_rdata; take_seen = take; put_seen = put;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(1); chk("R1 icr", d, 8'h00);
        rd_reg(2); chk("R1 mode", d, 8'h00);
        rd_reg(3); chk("R1 tcr", d, 8'h00);
        chk("R1 drive", {drv_vec, irq, dout}, 14'h0);

        // R2 command register
        wr_reg(1, 8'h7F);
        rd_reg(1); chk("R2 readback", d, 8'h1F);
        chk("R2 drive", drv_vec, 5'h1F);

        // R3 data enable forced off in target-to-initiator phase
        busy = 1'b1; phase = 3'b001; #1;
        chk("R3 in-phase", drv_vec, 5'h1E);
        phase = 3'b010; #1;
        chk("R3 out-phase", drv_vec, 5'h1F);
        busy = 1'b0; phase = 3'b000;

        // R4 ACK gated by DMA mode
        wr_reg(2, 8'h02); chk("R4 dma mode", drv_vec, 5'h0F);
        wr_reg(2, 8'h00); chk("R4 normal", drv_vec, 5'h1F);

        // R14 live bus and phase match
        busy = 1'b1; phase = 3'b110; req = 1'b1; sel = 1'b1;
        wr_reg(3, 8'h06);
        rd_reg(4); chk("R14 bus", d, 8'h7A);
        rd_reg(5); chk("R14 match", d, 8'h08);
        busy = 1'b0; phase = 3'b000; req = 1'b0; sel = 1'b0;
        wr_reg(3, 8'h00);

        // R6 DMA starts
        wr_reg(2, 8'h40); wr_reg(5, 8'h11);
        rd_reg(5); chk("R6 start ignored", d, 8'h00);
        wr_reg(2, 8'h42); wr_reg(6, 8'h55);
        rd_reg(5); chk("R6 request", d, 8'h40); chk("R6 dc no request", dd, 8'h00);
        // R7 clearing DMA mode
        wr_reg(2, 8'h40);
        rd_reg(5); chk("R7 ended", d, 8'h00);

        // R8 data paths
        din = 8'hA5;
        rd_reg(0); chk("R8 peek data", d, 8'hA5); chk("R8 peek no take", take_seen, 1'b0);
        rd_reg(6); chk("R8 in idle data", d, 8'hA5); chk("R8 in idle no take", take_seen, 1'b0);
        rd_reg(8); chk("R8 port take", take_seen, 1'b1);
        wr_reg(8, 8'h3C); chk("R8 port put", put_seen, 1'b1); chk("R8 port dout", dout, 8'h3C);
        wr_reg(0, 8'h5A); chk("R8 free put", put_seen, 1'b1); chk("R8 free dout", dout, 8'h5A);
        busy = 1'b1; phase = 3'b000;
        wr_reg(0, 8'h11); chk("R8 busy no put", put_seen, 1'b0);
        wr_reg(2, 8'h42); wr_reg(7, 8'h00);
        wr_reg(0, 8'h22); chk("R8 dma put", put_seen, 1'b1);
        rd_reg(6); chk("R8 dma take", take_seen, 1'b1);
        wr_reg(2, 8'h40);

        // R9 / R12 / R10 phase mismatch interrupt
        wr_reg(2, 8'h00);
        rd_reg(8);
        rd_reg(5); chk("R9 match no irq", d, 8'h08);
        phase = 3'b001;
        rd_reg(8);
        chk("R12 held k", irq, 1'b0); chk("R12 dc immediate", dc_irq, 1'b1);
        @(negedge clk); chk("R12 held k+1", irq, 1'b0);
        @(negedge clk); chk("R12 out k+2", irq, 1'b1);
        rd_reg(5); chk("R9 status", d, 8'h10); chk("R10 dc status", dd, 8'h90);
        rd_reg(3); chk("R10 tcr", d, 8'h00); chk("R10 dc tcr", dd, 8'h80);

        // R11 clear by reading index 7
        rd_reg(7); chk("R11 data", d, 8'h00);
        chk("R11 irq", {irq, dc_irq}, 2'b00);
        rd_reg(5); chk("R11 status", d, 8'h00); chk("R11 dc status", dd, 8'h80);

        // R9 suppressed by check-disable bit
        wr_reg(2, 8'h40);
        rd_reg(8);
        rd_reg(5); chk("R9 suppressed", d, 8'h00); chk("R9 dc suppressed", dd, 8'h00);

        // R13 indices above 8
        for (int a = 9; a < 16; a++) begin
            wr_reg(a, 8'($urandom));
            chk("R13 no put", put_seen, 1'b0);
        end
        rd_reg(1); chk("R13 icr kept", d, 8'h1F);
        rd_reg(2); chk("R13 mode kept", d, 8'h40);
        rd_reg(3); chk("R13 dc tcr kept", dd, 8'h80);
        for (int a = 9; a < 16; a++) begin
            rd_reg(a); chk("R13 read zero", d, 8'h00);
        end

        // R2 R3 R4 constrained random drive patterns
        for (int i = 0; i < 30; i++) begin
            logic [7:0] ic, md;
            ic = 8'($urandom) & 8'h7F;
            md = (8'($urandom) & 8'h02) | 8'h40;
            wr_reg(1, ic); wr_reg(2, md);
            busy = 1'($urandom); phase = 3'($urandom); #1;
            chk("R3 R4 random drive", drv_vec, exp_drv(ic, md, busy, phase));
            rd_reg(1); chk("R2 random readback", d, ic & 8'h1F);
        end
        busy = 1'b0;

        // R5 bus reset command
        wr_reg(2, 8'h42); wr_reg(7, 8'h00); wr_reg(1, 8'h1F);
        wr_reg(1, 8'h80); chk("R5 pulse", rst_seen, 1'b1);
        @(negedge clk); chk("R5 pulse ends", d_rst, 1'b0);
        rd_reg(1); chk("R5 icr", d, 8'h00);
        rd_reg(2); chk("R5 mode", d, 8'h00);
        rd_reg(3); chk("R5 dc tcr", dd, 8'h00);
        rd_reg(5); chk("R5 status", d, 8'h00);
        chk("R5 outputs", {drv_vec, irq}, 6'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule